// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive side of an Ethernet MAC. It watches a byte-wide frame stream and decides, for each frame, whether the destination address passes the programmed filters. The stream marks the first byte of a frame with a start flag and the last byte with an end flag. The block keeps the first six bytes of the frame as the destination address and counts the length of the frame.

Software programs the filters through a 32-bit write port. There are two exact-match station addresses, a 64-bit group hash table and a 4-bit receive control word. The block takes a copy of the whole configuration at frame start. It gives one registered verdict per frame: accept, plain drop, oversize or overrun.

An accepted frame stays pending until downstream logic returns a consume pulse. A later frame that passes the filters while a frame is still pending is reported as an overrun.

Top module: `rx_da_filter`

## Requirements
- R1: Byte-address writes store the registers as follows. Station 0 uses 0x00 (low) and 0x04 (high). Station 1 uses 0x08 (low) and 0x0C (high). The group table uses 0x10 (bits 31:0) and 0x14 (bits 63:32). Control uses 0x1C. Address byte k of a station (byte 0 first on the wire) sits in bits 8k+7:8k of the low word for k = 0..3. Bytes 4 and 5 sit in bits 7:0 and 15:8 of the high word. Writes to any other offset are ignored.
- R2: When control bit 0 (station 0) or control bit 1 (station 1) is set, a destination that equals that station address in all six bytes passes. When the bit is clear, that station never passes a frame.
- R3: When control bit 3 is set, the destination FF:FF:FF:FF:FF:FF passes. When it is clear, the broadcast destination passes only through another filter.
- R4: The hash index is the XOR of the eight 6-bit slices of the 48-bit destination value, where byte k sits in bits 8k+7:8k. The group check hits when table bit [index] is set. Indexes 32..63 select bit (index−32) of the word at 0x14.
- R5: A destination whose first byte has bit 0 clear is an individual address. It can hit the group check only when control bit 2 is set. A group address (bit 0 set) uses the group check whatever bit 2 holds.
- R6: A frame of fewer than 12 bytes is always dropped, and no flag is raised.
- R7: A frame that passes the filters and is longer than 1536 bytes is reported with the oversize flag set and accept clear.
- R8: A frame that passes the filters while an earlier accepted frame is still pending is reported with the overrun flag set and accept clear. The pending output rises with an accept and falls after a one-cycle consume pulse.
- R9: The verdict strobe is high for exactly the one cycle after the clock edge that takes the end-of-frame byte. In that cycle the length output equals the frame byte count plus 4.
- R10: The filter configuration is sampled when the start byte is taken. Register writes made during a frame do not change the verdict for that frame, and they apply from the next frame.
- R11: After reset every register is zero and nothing is pending. Every frame is then dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 8 | Register byte offset |
| cfg_wr_data | input | 32 | Register write data |
| rx_valid | input | 1 | Frame byte present |
| rx_data | input | 8 | Frame byte |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| pend_consume | input | 1 | Downstream has taken the pending frame |
| verdict_valid | output | 1 | One-cycle verdict strobe |
| verdict_accept | output | 1 | Frame accepted |
| verdict_oversize | output | 1 | Frame passed the filters but is too long |
| verdict_overrun | output | 1 | Frame passed the filters while another was pending |
| verdict_len | output | 17 | Byte count plus 4 |
| rx_pending | output | 1 | An accepted frame awaits consume |

## Verification
Some properties are checked on every cycle. At most one outcome flag is raised per verdict. An accepted length always lies between 16 and 1540. An oversize length always exceeds 1540. An overrun is only reported when a frame was pending, and pending is high whenever an accept appears.

Other behaviours need the bench's scenarios. These are the byte order of the station registers, the hash index for addresses landing in each table half, the gating of individual addresses by control bit 2, the 11 and 12 byte and the 1536 and 1537 byte boundaries, and mid-frame register writes that must not affect the current verdict.

// File: rtl/rxdaf_pkg.sv
package rxdaf_pkg;
  localparam int unsigned NUM_STA    = 2;
  localparam int unsigned ADDR_BYTES = 6;
  localparam int unsigned ADDR_W     = 8 * ADDR_BYTES;
  localparam int unsigned GRP_BITS   = 64;
  localparam int unsigned HASH_W     = $clog2(GRP_BITS);
  localparam int unsigned CTL_W      = 4;

  // control bit positions
  localparam int unsigned CTL_IND_HASH = 2;
  localparam int unsigned CTL_BCAST    = 3;

  // register byte offsets
  localparam logic [7:0] OFS_GRP_LO = 8'h10;
  localparam logic [7:0] OFS_GRP_HI = 8'h14;
  localparam logic [7:0] OFS_CTL    = 8'h1C;

  typedef struct packed {
    logic [CTL_W-1:0]                ctl;
    logic [GRP_BITS-1:0]             grp;
    logic [NUM_STA-1:0][ADDR_W-1:0]  sta;
  } filt_cfg_t;
endpackage

// File: rtl/rxdaf_regs.sv
module rxdaf_regs
  import rxdaf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  wr_addr,
  input  logic [31:0] wr_data,
  output filt_cfg_t   cfg
);
  logic [31:0] grp_lo_q, grp_hi_q;
  logic [CTL_W-1:0] ctl_q;

  generate
    for (genvar s = 0; s < NUM_STA; s++) begin : g_sta
      logic [31:0] lo_q;
      logic [15:0] hi_q;
      logic lo_we, hi_we;
      assign lo_we = wr_en && (wr_addr == 8'(s * 8));
      assign hi_we = wr_en && (wr_addr == 8'(s * 8 + 4));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lo_q <= '0;
          hi_q <= '0;
        end else begin
          if (lo_we) lo_q <= wr_data;
          if (hi_we) hi_q <= wr_data[15:0];
        end
      end
      assign cfg.sta[s] = {hi_q, lo_q};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_lo_q <= '0;
      grp_hi_q <= '0;
      ctl_q    <= '0;
    end else begin
      if (wr_en && wr_addr == OFS_GRP_LO) grp_lo_q <= wr_data;
      if (wr_en && wr_addr == OFS_GRP_HI) grp_hi_q <= wr_data;
      if (wr_en && wr_addr == OFS_CTL)    ctl_q    <= wr_data[CTL_W-1:0];
    end
  end

  assign cfg.grp = {grp_hi_q, grp_lo_q};
  assign cfg.ctl = ctl_q;
endmodule

// File: rtl/rxdaf_match.sv
module rxdaf_match
  import rxdaf_pkg::*;
(
  input  filt_cfg_t         cfg,
  input  logic [ADDR_W-1:0] dest,
  output logic              pass
);
  localparam int unsigned SLICES = ADDR_W / HASH_W;

  logic [NUM_STA-1:0] sta_hit;
  logic [HASH_W-1:0]  hidx;
  logic               bc_hit, grp_hit;

  generate
    for (genvar s = 0; s < NUM_STA; s++) begin : g_cmp
      assign sta_hit[s] = cfg.ctl[s] && (dest == cfg.sta[s]);
    end
  endgenerate

  always_comb begin
    hidx = '0;
    for (int k = 0; k < SLICES; k++) hidx ^= dest[k*HASH_W +: HASH_W];
  end

  assign bc_hit  = cfg.ctl[CTL_BCAST] && (&dest);
  assign grp_hit = (dest[0] || cfg.ctl[CTL_IND_HASH]) && cfg.grp[hidx];
  assign pass    = (|sta_hit) || bc_hit || grp_hit;
endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
  import rxdaf_pkg::*;
#(
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned MIN_LEN   = 12,
  parameter int unsigned MAX_LEN   = 1536,
  parameter int unsigned CRC_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [7:0]       cfg_wr_addr,
  input  logic [31:0]      cfg_wr_data,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_sof,
  input  logic             rx_eof,
  input  logic             pend_consume,
  output logic             verdict_valid,
  output logic             verdict_accept,
  output logic             verdict_oversize,
  output logic             verdict_overrun,
  output logic [LEN_W:0]   verdict_len,
  output logic             rx_pending
);
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);
  localparam logic [LEN_W:0]   CRC_L = (LEN_W+1)'(CRC_BYTES);

  filt_cfg_t cfg_live, cfg_q, cfg_nxt;
  logic [ADDR_W-1:0] dest_q, dest_nxt;
  logic [LEN_W-1:0]  cnt_q, cnt_nxt;
  logic in_frame_q, in_frame_nxt, pend_q, pend_nxt;
  logic vld_q, acc_q, ovs_q, orun_q;
  logic acc_nxt, ovs_nxt, orun_nxt;
  logic [LEN_W:0] len_q, len_nxt;
  logic start, take, last, pass, ok, big, short_f;

  rxdaf_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr),
    .wr_data(cfg_wr_data), .cfg(cfg_live)
  );

  rxdaf_match u_match (.cfg(cfg_q), .dest(dest_q), .pass(pass));

  assign start = rx_valid && rx_sof;
  assign take  = rx_valid && (rx_sof || in_frame_q);
  assign last  = take && rx_eof;

  // next-state
  always_comb begin
    cnt_nxt  = cnt_q;
    dest_nxt = dest_q;
    cfg_nxt  = cfg_q;
    if (start) begin
      cnt_nxt  = LEN_W'(1);
      dest_nxt = {{(ADDR_W-8){1'b0}}, rx_data};
      cfg_nxt  = cfg_live;
    end else if (take) begin
      cnt_nxt = (&cnt_q) ? cnt_q : cnt_q + 1'b1;
      for (int b = 1; b < ADDR_BYTES; b++)
        if (cnt_q == LEN_W'(b)) dest_nxt[b*8 +: 8] = rx_data;
    end
    in_frame_nxt = last ? 1'b0 : (start ? 1'b1 : in_frame_q);

    short_f  = cnt_nxt < MIN_L;
    big      = cnt_nxt > MAX_L;
    ok       = last && !short_f && pass;
    acc_nxt  = ok && !big && !pend_q;
    ovs_nxt  = ok && big;
    orun_nxt = ok && !big && pend_q;
    len_nxt  = last ? ({1'b0, cnt_nxt} + CRC_L) : len_q;
    pend_nxt = (pend_q && !pend_consume) || acc_nxt;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      dest_q     <= '0;
      cnt_q      <= '0;
      in_frame_q <= 1'b0;
      pend_q     <= 1'b0;
      vld_q      <= 1'b0;
      acc_q      <= 1'b0;
      ovs_q      <= 1'b0;
      orun_q     <= 1'b0;
      len_q      <= '0;
    end else begin
      if (start) cfg_q <= cfg_nxt;
      if (take) begin
        dest_q <= dest_nxt;
        cnt_q  <= cnt_nxt;
      end
      in_frame_q <= in_frame_nxt;
      pend_q     <= pend_nxt;
      vld_q      <= last;
      acc_q      <= acc_nxt;
      ovs_q      <= ovs_nxt;
      orun_q     <= orun_nxt;
      if (last) len_q <= len_nxt;
    end
  end

  assign verdict_valid    = vld_q;
  assign verdict_accept   = acc_q;
  assign verdict_oversize = ovs_q;
  assign verdict_overrun  = orun_q;
  assign verdict_len      = len_q;
  assign rx_pending       = pend_q;

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |-> $countones({verdict_accept, verdict_oversize, verdict_overrun}) <= 1); // R7
  AST_ACCEPT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && verdict_accept) |->
      (verdict_len >= {1'b0, MIN_L} + CRC_L && verdict_len <= {1'b0, MAX_L} + CRC_L)); // R6
  AST_OVERSIZE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && verdict_oversize) |-> verdict_len > {1'b0, MAX_L} + CRC_L); // R7
  AST_OVERRUN_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && verdict_overrun) |-> $past(rx_pending)); // R8
  AST_ACCEPT_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && verdict_accept) |-> rx_pending); // R8
endmodule

// File: tb/sim_rx_da_filter.sv
`timescale 1ns/1ps
module sim_rx_da_filter;
  logic clk = 1'b0;
  logic rst_n;
  logic cfg_wr_en;
  logic [7:0] cfg_wr_addr;
  logic [31:0] cfg_wr_data;
  logic rx_valid, rx_sof, rx_eof, pend_consume;
  logic [7:0] rx_data;
  logic verdict_valid, verdict_accept, verdict_oversize, verdict_overrun, rx_pending;
  logic [16:0] verdict_len;

  int n_chk = 0;
  int n_bad = 0;
  logic [47:0] BC = 48'hFFFF_FFFF_FFFF;

  always #5 clk = ~clk;

  rx_da_filter u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
    .cfg_wr_data(cfg_wr_data), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .pend_consume(pend_consume),
    .verdict_valid(verdict_valid), .verdict_accept(verdict_accept),
    .verdict_oversize(verdict_oversize), .verdict_overrun(verdict_overrun),
    .verdict_len(verdict_len), .rx_pending(rx_pending)
  );

  task automatic chk(string req, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic logic [5:0] hidx(logic [47:0] d);
    logic [5:0] h = '0;
    for (int k = 0; k < 8; k++) h ^= d[k*6 +: 6];
    return h;
  endfunction

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic set_sta(int s, logic [47:0] d);
    wr(8'(s*8), d[31:0]);
    wr(8'(s*8+4), {16'h0, d[47:32]});
  endtask

  task automatic set_grp(logic [63:0] t);
    wr(8'h10, t[31:0]);
    wr(8'h14, t[63:32]);
  endtask

  // sends a frame; optionally writes a register during byte 3
  task automatic frame(logic [47:0] d, int len, bit mid_wr = 0,
                       logic [7:0] wa = 8'h0, logic [31:0] wd = 32'h0);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_sof   = (i == 0);
      rx_eof   = (i == len - 1);
      rx_data  = (i < 6) ? d[i*8 +: 8] : 8'(i);
      cfg_wr_en = mid_wr && (i == 3);
      cfg_wr_addr = wa; cfg_wr_data = wd;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; cfg_wr_en = 1'b0;
  endtask

  // sampled in the cycle right after the end byte
  task automatic expv(string req, bit acc, bit ovs, bit orun, int len);
    chk(req, "valid", int'(verdict_valid), 1);
    chk(req, "accept", int'(verdict_accept), int'(acc));
    chk(req, "oversize", int'(verdict_oversize), int'(ovs));
    chk(req, "overrun", int'(verdict_overrun), int'(orun));
    if (acc || ovs) chk(req, "len", int'(verdict_len), len + 4);
    @(negedge clk);
    chk(req, "strobe one cycle", int'(verdict_valid), 0);
  endtask

  task automatic consume();
    @(negedge clk); pend_consume = 1'b1;
    @(negedge clk); pend_consume = 1'b0;
    chk("R8", "pending after consume", int'(rx_pending), 0);
  endtask

  task automatic t_reset();
    chk("R11", "valid at reset", int'(verdict_valid), 0);
    chk("R11", "pending at reset", int'(rx_pending), 0);
    frame(BC, 64); expv("R11", 0, 0, 0, 64);
  endtask

  task automatic t_station();
    logic [47:0] s0 = 48'h5544_3322_1102;
    logic [47:0] s1 = 48'h01EE_DDCC_BB0A;
    set_sta(0, s0); set_sta(1, s1); wr(8'h1C, 32'h3);
    frame(s0, 64); expv("R1", 1, 0, 0, 64); consume();
    frame(s1, 64); expv("R2", 1, 0, 0, 64); consume();
    frame(s0 ^ 48'h0100_0000_0000, 64); expv("R2", 0, 0, 0, 64);
    frame({s0[7:0], s0[47:8]}, 64); expv("R1", 0, 0, 0, 64);
    wr(8'h18, 32'hF); // unused offset
    wr(8'h1C, 32'h1);
    frame(s1, 64); expv("R2", 0, 0, 0, 64);
    frame(s0, 64); expv("R2", 1, 0, 0, 64); consume();
  endtask

  task automatic t_bcast();
    wr(8'h1C, 32'h0);
    frame(BC, 64); expv("R3", 0, 0, 0, 64);
    wr(8'h1C, 32'h8);
    frame(BC, 100); expv("R3", 1, 0, 0, 100); consume();
  endtask

  task automatic t_hash();
    logic [47:0] g = 48'hFB00_005E_0001;
    logic [47:0] gh = 48'h0005_0403_0201;
    logic [63:0] t;
    wr(8'h1C, 32'h0);
    t = 64'h1 << hidx(g); set_grp(t);
    frame(g, 64); expv("R4", 1, 0, 0, 64); consume();
    set_grp(~t);
    frame(g, 64); expv("R4", 0, 0, 0, 64);
    for (int b = 0; b < 256; b++) begin
      gh[47:40] = 8'(b);
      if (hidx(gh) >= 6'd32) break;
    end
    t = 64'h1 << hidx(gh); set_grp(t);
    frame(gh, 64); expv("R4", 1, 0, 0, 64); consume();
  endtask

  task automatic t_indiv();
    logic [47:0] ia = 48'h6655_4433_2202;
    set_grp('1); wr(8'h1C, 32'h0);
    frame(ia, 64); expv("R5", 0, 0, 0, 64);
    wr(8'h1C, 32'h4);
    frame(ia, 64); expv("R5", 1, 0, 0, 64); consume();
    set_grp('0);
  endtask

  task automatic t_short();
    wr(8'h1C, 32'h8);
    frame(BC, 11); expv("R6", 0, 0, 0, 11);
    frame(BC, 12); expv("R6", 1, 0, 0, 12); consume();
  endtask

  task automatic t_oversize();
    frame(BC, 1537); expv("R7", 0, 1, 0, 1537);
    chk("R7", "no pending", int'(rx_pending), 0);
    frame(BC, 1536); expv("R7", 1, 0, 0, 1536); consume();
  endtask

  task automatic t_overrun();
    frame(BC, 64); expv("R8", 1, 0, 0, 64);
    chk("R8", "pending set", int'(rx_pending), 1);
    frame(BC, 70); expv("R8", 0, 0, 1, 70);
    chk("R8", "pending held", int'(rx_pending), 1);
    consume();
    frame(BC, 70); expv("R9", 1, 0, 0, 70); consume();
  endtask

  task automatic t_snapshot();
    frame(BC, 64, 1, 8'h1C, 32'h0); expv("R10", 1, 0, 0, 64); consume();
    frame(BC, 64); expv("R10", 0, 0, 0, 64);
    frame(BC, 64, 1, 8'h1C, 32'h8); expv("R10", 0, 0, 0, 64);
    frame(BC, 64); expv("R10", 1, 0, 0, 64); consume();
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_addr = '0; cfg_wr_data = '0;
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = '0; pend_consume = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_station();
    t_bcast();
    t_hash();
    t_indiv();
    t_short();
    t_oversize();
    t_overrun();
    t_snapshot();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule